// File: doc/BRIEF.md
# Periodic Entropy Reseed Requester

This block keeps a key-derivation engine supplied with fresh 128-bit seed material. Each refresh fetches two 64-bit words from an entropy source that runs on a different clock. It uses a four-phase request/acknowledge handshake. The acknowledge is brought into the core clock through a flop synchroniser. The second fetch of a refresh follows as soon as the first has fully completed. The two words are packed into one 128-bit register, and a single-cycle valid strobe marks each finished refresh.

The first refresh after reset is started only by a command pulse (`advance_i`). That pulse represents the engine's advance into its initialised state. Once one refresh has completed and `enable_i` is high, the block repeats refreshes on its own. An idle counter spaces them, and `interval_i` programs its length. The intended setting is 0x100 core cycles. The counter is held at zero while a refresh is in flight and counts only while the block is idle.

The entropy source must hold `ent_data_i` stable from the moment it raises `ent_ack_i` until it sees `ent_req_o` fall.

Top module: `reseed_requester`

## Requirements
- R1: A synchronous active-low reset forces `ent_req_o` low, `seed_valid_o` low and `seed_o` to zero. It also clears the half-select bit, the idle counter and the armed state. After reset the next refresh loads the low half first, and no periodic fetch happens until a commanded refresh has completed again.
- R2: Once raised, `ent_req_o` stays high until `ent_ack_i` has been seen high through the SYNC_STAGES-flop synchroniser. With an acknowledge that arrives two cycles after the request, the request stays high for at least four cycles.
- R3: A one-cycle `advance_i` pulse sampled while the block is idle raises `ent_req_o` on the next cycle, whatever the level of `enable_i`.
- R4: The word delivered by the first fetch of a refresh is stored in `seed_o[63:0]`. The word delivered by the second fetch is stored in `seed_o[127:64]`. Each word is taken in the cycle where the request is high and the synchronised acknowledge is high.
- R5: `seed_valid_o` is high for exactly one cycle, the cycle after the second word is stored. `seed_o` keeps its value afterwards.
- R6: The second request of a refresh is raised at most 20 core cycles after the first request falls.
- R7: No request is raised without `advance_i` unless `enable_i` is high and at least one refresh has completed since reset.
- R8: A periodic refresh starts no earlier than `interval_i` cycles and no later than `interval_i`+20 cycles after the previous refresh ends. The idle count restarts from zero after every refresh.
- R9: An `advance_i` pulse that arrives while a refresh is in flight is ignored, and no extra refresh follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Allows periodic refreshes once the block is armed |
| advance_i | input | 1 | Command pulse that starts a refresh immediately |
| interval_i | input | CNT_W (16) | Idle cycles between refreshes |
| ent_req_o | output | 1 | Request to the entropy source |
| ent_ack_i | input | 1 | Acknowledge from the entropy clock domain |
| ent_data_i | input | WORD_W (64) | Entropy word, valid while acknowledge is high |
| seed_o | output | 2*WORD_W (128) | Assembled seed |
| seed_valid_o | output | 1 | One-cycle strobe when both halves are loaded |

## Verification
The bench targets these corner cases:
- **Idle timer firing too early.** The bench runs with enable high before any command has been given. A design that lets the timer fire here issues a request with no command behind it.
- **Half-select bit surviving reset.** The bench resets in the middle of a refresh. A design that keeps the bit would swap the two halves of the next seed.
- **Advance pulse during a refresh.** A command that lands mid-refresh is checked for not producing a second refresh. The following idle window is checked for staying quiet while enable is low.
- **Request dropped early or second fetch late.** The bench measures how long the request stays high, and the gap before the second fetch. A design that drops the request before the synchronised acknowledge, or stalls the second fetch, breaks those measurements.
- **Interval window.** The spacing is checked against a window at two different interval settings.

// File: rtl/reseed_pkg.sv
// Shared types for the entropy reseed requester.
package reseed_pkg;

    // Handshake phase of the request port.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no request outstanding
        ST_REQ  = 2'd1,   // request high, waiting for synchronised ack
        ST_DROP = 2'd2    // request low, waiting for synchronised ack to clear
    } req_state_e;

endpackage

// File: rtl/reseed_sync.sv
// Multi-flop synchroniser for a level crossing into the core clock.
// Assumes the input is a slow level, as a four-phase handshake provides.
module reseed_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= async_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk_i) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/reseed_timer.sv
// Idle-interval counter. Held at zero while a fetch is in flight, counts
// (saturating) while idle, and flags expiry once the count reaches the limit.
module reseed_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             idle_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    // Count idle cycles; restart whenever the handshake is busy.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)             cnt_q <= '0;
        else if (!idle_i)        cnt_q <= '0;
        else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = idle_i && (cnt_q >= limit_i);

endmodule

// File: rtl/reseed_fsm.sv
// Request handshake controller. Runs one four-phase handshake per word,
// two words per refresh, tracked by a half-select bit. Assumes ack_sync_i
// is already synchronised to clk_i.
module reseed_fsm
    import reseed_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic enable_i,
    input  logic advance_i,
    input  logic expired_i,
    input  logic ack_sync_i,
    output logic req_o,
    output logic idle_o,
    output logic capture_o,
    output logic phase_o
);

    req_state_e state_q, state_d;
    logic       phase_q;
    logic       armed_q;
    logic       start;

    assign start     = advance_i || (enable_i && armed_q && expired_i);
    assign capture_o = (state_q == ST_REQ) && ack_sync_i;

    // Next-state selection for the handshake.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start)       state_d = ST_REQ;
            ST_REQ:  if (ack_sync_i)  state_d = ST_DROP;
            ST_DROP: if (!ack_sync_i) state_d = phase_q ? ST_REQ : ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Half-select bit flips on every captured word.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)        phase_q <= 1'b0;
        else if (capture_o) phase_q <= ~phase_q;
    end

    // Armed once a complete refresh has been fetched.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                   armed_q <= 1'b0;
        else if (capture_o && phase_q) armed_q <= 1'b1;
    end

    assign req_o   = (state_q == ST_REQ);
    assign idle_o  = (state_q == ST_IDLE);
    assign phase_o = phase_q;

endmodule

// File: rtl/reseed_assemble.sv
// Seed assembly register: writes the captured word into the half chosen by
// the half-select bit and strobes valid after the upper half is written.
module reseed_assemble #(
    parameter int WORD_W = 64
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                capture_i,
    input  logic                phase_i,
    input  logic [WORD_W-1:0]   word_i,
    output logic [2*WORD_W-1:0] seed_o,
    output logic                valid_o
);

    logic [WORD_W-1:0] half_q [2];
    logic              valid_q;

    // One register per seed half, selected by the half-select bit.
    generate
        for (genvar g = 0; g < 2; g++) begin : g_half
            always_ff @(posedge clk_i) begin
                if (!rst_ni)                             half_q[g] <= '0;
                else if (capture_i && (phase_i == g[0])) half_q[g] <= word_i;
            end
        end
    endgenerate

    // Strobe when the upper half lands.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) valid_q <= 1'b0;
        else         valid_q <= capture_i && phase_i;
    end

    assign seed_o  = {half_q[1], half_q[0]};
    assign valid_o = valid_q;

endmodule

// File: rtl/reseed_requester.sv
// Periodic entropy reseed requester: fetches two words per refresh over a
// four-phase handshake from another clock domain, spaces refreshes by an
// idle interval, and lets a command pulse start one at once.
// Assumes the source holds ent_data_i stable while ent_ack_i is high.
module reseed_requester #(
    parameter int WORD_W      = 64,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                enable_i,
    input  logic                advance_i,
    input  logic [CNT_W-1:0]    interval_i,
    output logic                ent_req_o,
    input  logic                ent_ack_i,
    input  logic [WORD_W-1:0]   ent_data_i,
    output logic [2*WORD_W-1:0] seed_o,
    output logic                seed_valid_o
);

    localparam int SEED_W = 2 * WORD_W;

    logic ack_sync;
    logic idle;
    logic expired;
    logic capture;
    logic phase;
    logic [SEED_W-1:0] seed;

    reseed_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (ent_ack_i),
        .sync_o  (ack_sync)
    );

    reseed_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .idle_i    (idle),
        .limit_i   (interval_i),
        .expired_o (expired)
    );

    reseed_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .enable_i   (enable_i),
        .advance_i  (advance_i),
        .expired_i  (expired),
        .ack_sync_i (ack_sync),
        .req_o      (ent_req_o),
        .idle_o     (idle),
        .capture_o  (capture),
        .phase_o    (phase)
    );

    reseed_assemble #(.WORD_W(WORD_W)) u_asm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .capture_i (capture),
        .phase_i   (phase),
        .word_i    (ent_data_i),
        .seed_o    (seed),
        .valid_o   (seed_valid_o)
    );

    assign seed_o = seed;

endmodule

// File: rtl/reseed_requester_chk.sv
// Protocol checker for the reseed requester, attached by bind.
// Observes the ports plus the synchronised ack and half-select bit.
module reseed_requester_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             enable_i,
    input logic             advance_i,
    input logic [CNT_W-1:0] interval_i,
    input logic             ent_req_o,
    input logic             seed_valid_o,
    input logic             ack_sync,
    input logic             phase
);

    logic [4:0]     gap2_q;
    logic [CNT_W:0] idle_q;

    // Cycles spent waiting to raise the second request after the first completed.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                               gap2_q <= '0;
        else if (phase && !ent_req_o && !ack_sync) gap2_q <= (gap2_q != '1) ? gap2_q + 1'b1 : gap2_q;
        else                                       gap2_q <= '0;
    end

    // Cycles with no request since the last refresh ended.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                  idle_q <= '0;
        else if (ent_req_o || phase)  idle_q <= '0;
        else if (idle_q != '1)        idle_q <= idle_q + 1'b1;
    end

    AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ent_req_o && !ack_sync |=> ent_req_o); // R2

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seed_valid_o |=> !seed_valid_o); // R5

    AST_VALID_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seed_valid_o |-> !phase); // R5

    AST_SECOND_PROMPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gap2_q < 5'd20); // R6

    AST_PERIODIC_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ent_req_o) && !phase && !$past(advance_i) |-> $past(enable_i)); // R7

    AST_INTERVAL_RESPECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ent_req_o) && !phase && !$past(advance_i) |-> idle_q >= {1'b0, interval_i}); // R8

endmodule

bind reseed_requester reseed_requester_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (enable_i),
    .advance_i    (advance_i),
    .interval_i   (interval_i),
    .ent_req_o    (ent_req_o),
    .seed_valid_o (seed_valid_o),
    .ack_sync     (ack_sync),
    .phase        (phase)
);

// File: tb/tb_reseed_requester.sv
module tb_reseed_requester;

    localparam int WORD_W = 64;
    localparam int CNT_W  = 16;
    localparam int ACK_DLY = 2;

    typedef struct packed {
        logic [WORD_W-1:0] lo;
        logic [WORD_W-1:0] hi;
        logic [CNT_W-1:0]  gap;
        logic              periodic;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{lo: 64'h0123_4567_89AB_CDEF, hi: 64'hFEDC_BA98_7654_3210, gap: 16'd16,   periodic: 1'b0},
        '{lo: 64'hA5A5_0000_FFFF_5A5A, hi: 64'h1111_2222_3333_4444, gap: 16'd16,   periodic: 1'b1},
        '{lo: 64'hDEAD_BEEF_CAFE_F00D, hi: 64'h0F0F_F0F0_1234_8765, gap: 16'd40,   periodic: 1'b1},
        '{lo: 64'h8000_0000_0000_0001, hi: 64'h7FFF_FFFF_FFFF_FFFE, gap: 16'd1000, periodic: 1'b0}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                enable = 1'b0;
    logic                advance = 1'b0;
    logic [CNT_W-1:0]    interval = 16'd256;
    logic                ent_req;
    logic                ent_ack = 1'b0;
    logic [WORD_W-1:0]   ent_data = '0;
    logic [2*WORD_W-1:0] seed;
    logic                seed_valid;

    logic [WORD_W-1:0] w0 = '0;
    logic [WORD_W-1:0] w1 = '0;
    logic              idx = 1'b0;
    int                dly = 0;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    reseed_requester #(.WORD_W(WORD_W), .CNT_W(CNT_W), .SYNC_STAGES(2)) dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .enable_i     (enable),
        .advance_i    (advance),
        .interval_i   (interval),
        .ent_req_o    (ent_req),
        .ent_ack_i    (ent_ack),
        .ent_data_i   (ent_data),
        .seed_o       (seed),
        .seed_valid_o (seed_valid)
    );

    // Entropy source model: four-phase responder, ACK_DLY cycles each way.
    always @(negedge clk) begin
        if (!rst_n) begin
            ent_ack <= 1'b0;
            idx     <= 1'b0;
            dly     <= 0;
        end else if (ent_req && !ent_ack) begin
            if (dly == ACK_DLY - 1) begin
                ent_ack  <= 1'b1;
                ent_data <= idx ? w1 : w0;
                idx      <= ~idx;
                dly      <= 0;
            end else dly <= dly + 1;
        end else if (!ent_req && ent_ack) begin
            if (dly == ACK_DLY - 1) begin
                ent_ack <= 1'b0;
                dly     <= 0;
            end else dly <= dly + 1;
        end else dly <= 0;
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Count negedges until the request is high (0 if already high).
    task automatic wait_req(output int n, input int lim);
        n = 0;
        while (!ent_req && n < lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_valid(output int n, input int lim);
        n = 0;
        while (!seed_valid && n < lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic high_len(output int n);
        n = 0;
        while (ent_req && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse_advance();
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
    endtask

    task automatic quiet_window(input int len, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (ent_req) seen = 1'b1;
        end
        chk(!seen, req, seen, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        int n2;
        @(negedge clk);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ent_req == 1'b0, "R1 req in reset", ent_req, 0);
        chk(seed_valid == 1'b0, "R1 valid in reset", seed_valid, 0);
        chk(seed == '0, "R1 seed in reset", seed, 0);
        rst_n = 1'b1;

        // R7: enable high but no command yet -> no request
        enable   = 1'b1;
        interval = 16'd16;
        quiet_window(100, "R7 no request before first command");

        // Vector table walk
        for (int v = 0; v < 4; v++) begin
            w0 = VECS[v].lo;
            w1 = VECS[v].hi;
            interval = VECS[v].gap;
            if (!VECS[v].periodic) begin
                repeat (10) @(negedge clk);
                pulse_advance();
                chk(ent_req == 1'b1, "R3 request one cycle after command", ent_req, 1);
            end else begin
                wait_req(n, int'(VECS[v].gap) + 60);
                chk(n >= int'(VECS[v].gap) && n <= int'(VECS[v].gap) + 20,
                    "R8 periodic spacing", n, VECS[v].gap);
            end
            high_len(n);
            chk(n >= 4, "R2 request held until synchronised ack", n, 4);
            wait_req(n2, 100);
            chk(n2 <= 20 && ent_req, "R6 second request prompt", n2, 20);
            wait_valid(n, 100);
            chk(seed_valid && seed == {VECS[v].hi, VECS[v].lo}, "R4 seed halves",
                seed, {VECS[v].hi, VECS[v].lo});
            @(negedge clk);
            chk(!seed_valid && seed == {VECS[v].hi, VECS[v].lo}, "R5 single-cycle valid, seed held",
                {127'd0, seed_valid}, 0);
        end

        // R9: command during a refresh is ignored; R7: enable low stops periodic
        repeat (10) @(negedge clk);
        enable   = 1'b0;
        interval = 16'd16;
        w0 = 64'h1357_9BDF_0246_8ACE;
        w1 = 64'hECA8_6420_FDB9_7531;
        pulse_advance();
        pulse_advance();
        wait_valid(n, 100);
        chk(seed == {w1, w0}, "R9 refresh completes normally", seed, {w1, w0});
        quiet_window(80, "R9 no extra refresh after mid-refresh command");
        chk(seed_valid == 1'b0, "R7 enable low keeps block idle", seed_valid, 0);

        // R1: reset in the middle of a refresh
        w0 = 64'h0000_0000_AAAA_AAAA;
        w1 = 64'h5555_5555_0000_0000;
        pulse_advance();
        high_len(n);   // first word captured, half-select now on upper half
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!ent_req && !seed_valid, "R1 outputs cleared by mid-refresh reset", {ent_req, seed_valid}, 0);
        chk(seed == '0, "R1 seed cleared by mid-refresh reset", seed, 0);
        rst_n = 1'b1;
        @(negedge clk);
        w0 = 64'h2468_ACE0_1357_9BDF;
        w1 = 64'hFFFF_0000_FFFF_0000;
        pulse_advance();
        wait_valid(n, 100);
        chk(seed_valid && seed == {w1, w0}, "R1 half-select cleared by reset", seed, {w1, w0});

        // R1: armed state cleared by reset
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        enable   = 1'b1;
        interval = 16'd16;
        quiet_window(80, "R1 no periodic fetch after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule